// File: doc/BRIEF.md
# Global-Shutter Frame Sequencer

This block derives all the control strobes for a small snapshot-mode pixel array. Its only inputs are a master clock and an active-low start line. Its only job is to repeat one frame schedule. At the top of each frame, a hold-transfer pulse copies the integrated value of every pixel into that pixel's own hold storage. After a short gap, a global pixel reset returns all pixels to their bias level, so the next integration can start. While the new frame integrates, the held values are scanned out one pixel per clock. The scan uses one-hot row and column select buses.

The master clock runs at the pixel rate. The frame length, the pulse widths, the gap between transfer and reset, and the array shape are all parameters. The defaults are a 2500-clock frame, which gives a 2 kHz frame rate at a 5 MHz pixel clock, and a 4 x 4 array. The parameters are checked at elaboration. Every output comes straight from a flop. Holding the start line low clears the schedule on the next clock edge. Releasing it starts a fresh frame from the beginning.

Top module: `snap_tgen`

## Requirements
- R1: While `sp_n` is sampled low at a clock edge, every output is 0 after that edge and the frame position returns to its start.
- R2: After `sp_n` goes high, `frame_start` is high for exactly one clock, after the second rising edge at which `sp_n` is high. It then recurs every FRAME_LEN clocks.
- R3: `xfer` is high for XFER_W consecutive clocks. It starts in the same clock as `frame_start`.
- R4: `pix_rst` is high for RST_W consecutive clocks. It starts GAP_W clocks after `xfer` falls.
- R5: `xfer` and `pix_rst` are never high together. `xfer` is low in the clock before `pix_rst` rises.
- R6: Readout starts in the clock after `xfer` falls and visits the ROWS*COLS pixels in row-major order, one per clock. Bit i of `row_sel` selects row i and bit j of `col_sel` selects column j. The column advances every clock, and the row advances after the last column.
- R7: During the readout window exactly one bit of `row_sel` and one bit of `col_sel` is high. Outside the window both buses are all zero.
- R8: If `sp_n` goes low in the middle of a frame (during transfer or during readout), the outputs go inactive. After `sp_n` is released, the frame restarts from its first clock with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, equal to the pixel rate |
| sp_n | input | 1 | Active-low start line; low holds the sequence cleared |
| frame_start | output | 1 | One-clock marker on the first clock of each frame |
| xfer | output | 1 | Global hold-transfer pulse |
| pix_rst | output | 1 | Global pixel reset pulse |
| row_sel | output | ROWS | One-hot row select |
| col_sel | output | COLS | One-hot column select |

## Verification
The bench compares every output on every clock of more than two full frames against a schedule it computes itself. This catches two kinds of error. An off-by-one frame length would drift the second `frame_start`. A transfer that ran into the reset would break the transfer-before-reset ordering that the snapshot depends on. The row rollover after the last column and the final pixel of the window are compared cycle by cycle. A scan that advanced the row one pixel early or ran one pixel long would show up there. The start line is dropped once during the transfer and once mid-readout. A design that resumed the old frame position, or that left a select line high during the abort, would fail those comparisons.

// File: rtl/snap_tgen_pkg.sv
package snap_tgen_pkg;

   // true when position lies in [first, first+len)
   function automatic logic in_span(input logic [31:0] pos,
                                    input int unsigned first,
                                    input int unsigned len);
      return (pos >= first) && (pos < first + len);
   endfunction

   // widen a counter value to 32 bits
   function automatic logic [31:0] widen(input logic [31:0] v);
      return v;
   endfunction

endpackage

// File: rtl/tgen_frame_cnt.sv
module tgen_frame_cnt #(
   parameter int unsigned FRAME_LEN = 2500,
   localparam int unsigned CW       = $clog2(FRAME_LEN)
) (
   input  logic          clk,
   input  logic          sp_n,
   output logic [CW-1:0] cnt,
   output logic          run
);
   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   always_ff @(posedge clk) begin
      if (!sp_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else begin
         run <= 1'b1;
         if (run) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
      end
   end

   // R1: a low start line returns the position to zero
   a_r1_cnt_clear : assert property (@(posedge clk) !sp_n |=> (cnt == '0) && !run);
endmodule

// File: rtl/tgen_window.sv
module tgen_window #(
   parameter int unsigned START = 0,
   parameter int unsigned LEN   = 1,
   parameter int unsigned CW    = 12
) (
   input  logic          clk,
   input  logic          sp_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   output logic          q
);
   import snap_tgen_pkg::*;

   logic [31:0] pos;
   assign pos = {{(32-CW){1'b0}}, cnt};

   always_ff @(posedge clk) begin
      if (!sp_n) q <= 1'b0;
      else       q <= run && in_span(pos, START, LEN);
   end
endmodule

// File: rtl/tgen_scan.sv
module tgen_scan #(
   parameter int unsigned FIRST = 2,
   parameter int unsigned ROWS  = 4,
   parameter int unsigned COLS  = 4,
   parameter int unsigned CW    = 12,
   localparam int unsigned NPIX = ROWS * COLS
) (
   input  logic            clk,
   input  logic            sp_n,
   input  logic            run,
   input  logic [CW-1:0]   cnt,
   output logic [ROWS-1:0] row_sel,
   output logic [COLS-1:0] col_sel
);
   import snap_tgen_pkg::*;

   logic [31:0]     pos, pix, r_idx, c_idx;
   logic            win;
   logic [ROWS-1:0] row_d;
   logic [COLS-1:0] col_d;

   assign pos   = {{(32-CW){1'b0}}, cnt};
   assign win   = run && in_span(pos, FIRST, NPIX);
   assign pix   = pos - FIRST;
   assign r_idx = pix / COLS;
   assign c_idx = pix % COLS;

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      assign row_d[i] = win && (r_idx == i);
   end
   for (genvar j = 0; j < COLS; j++) begin : g_col
      assign col_d[j] = win && (c_idx == j);
   end

   always_ff @(posedge clk) begin
      if (!sp_n) begin
         row_sel <= '0;
         col_sel <= '0;
      end else begin
         row_sel <= row_d;
         col_sel <= col_d;
      end
   end

   // R7: at most one select per bus, and both buses active together
   a_r7_onehot : assert property (@(posedge clk) disable iff (!sp_n)
      $onehot0(row_sel) && $onehot0(col_sel) && ((|row_sel) == (|col_sel)));
   // R6: inside the window the column steps to the next bit
   a_r6_col_step : assert property (@(posedge clk) disable iff (!sp_n)
      (|col_sel) && !col_sel[COLS-1] && win |=> col_sel == $past(col_sel) << 1);
   // R6: after the last column the next pixel is column 0
   a_r6_col_wrap : assert property (@(posedge clk) disable iff (!sp_n)
      col_sel[COLS-1] && win |=> col_sel[0]);
endmodule

// File: rtl/snap_tgen.sv
module snap_tgen #(
   parameter int unsigned FRAME_LEN = 2500,
   parameter int unsigned XFER_W    = 2,
   parameter int unsigned GAP_W     = 1,
   parameter int unsigned RST_W     = 2,
   parameter int unsigned ROWS      = 4,
   parameter int unsigned COLS      = 4
) (
   input  logic            clk,
   input  logic            sp_n,
   output logic            frame_start,
   output logic            xfer,
   output logic            pix_rst,
   output logic [ROWS-1:0] row_sel,
   output logic [COLS-1:0] col_sel
);
   localparam int unsigned CW       = $clog2(FRAME_LEN);
   localparam int unsigned RST_AT   = XFER_W + GAP_W;
   localparam int unsigned SCAN_AT  = XFER_W;
   localparam int unsigned SCAN_END = SCAN_AT + ROWS * COLS;

   // elaboration-time parameter checks
   if (FRAME_LEN < 2)                  begin : g_bad_len  $error("FRAME_LEN below 2"); end
   if (XFER_W < 1 || GAP_W < 1 || RST_W < 1)
                                       begin : g_bad_w    $error("pulse widths below 1"); end
   if (ROWS < 1 || COLS < 1)           begin : g_bad_arr  $error("empty array"); end
   if (RST_AT + RST_W > FRAME_LEN)     begin : g_bad_rst  $error("reset past frame end"); end
   if (SCAN_END > FRAME_LEN)           begin : g_bad_scan $error("readout past frame end"); end

   logic [CW-1:0] cnt;
   logic          run;

   tgen_frame_cnt #(.FRAME_LEN(FRAME_LEN)) u_cnt (
      .clk(clk), .sp_n(sp_n), .cnt(cnt), .run(run));

   tgen_window #(.START(0), .LEN(1), .CW(CW)) u_fs (
      .clk(clk), .sp_n(sp_n), .run(run), .cnt(cnt), .q(frame_start));

   tgen_window #(.START(0), .LEN(XFER_W), .CW(CW)) u_xfer (
      .clk(clk), .sp_n(sp_n), .run(run), .cnt(cnt), .q(xfer));

   tgen_window #(.START(RST_AT), .LEN(RST_W), .CW(CW)) u_rst (
      .clk(clk), .sp_n(sp_n), .run(run), .cnt(cnt), .q(pix_rst));

   tgen_scan #(.FIRST(SCAN_AT), .ROWS(ROWS), .COLS(COLS), .CW(CW)) u_scan (
      .clk(clk), .sp_n(sp_n), .run(run), .cnt(cnt),
      .row_sel(row_sel), .col_sel(col_sel));

   // R1: start line low clears all outputs on the next edge
   a_r1_quiet : assert property (@(posedge clk)
      !sp_n |=> !frame_start && !xfer && !pix_rst && row_sel == '0 && col_sel == '0);
   // R3: transfer begins together with the frame marker
   a_r3_xfer_with_fs : assert property (@(posedge clk) disable iff (!sp_n)
      frame_start |-> xfer);
   // R2: the marker lasts one clock
   a_r2_fs_single : assert property (@(posedge clk) disable iff (!sp_n)
      frame_start |=> !frame_start);
   // R5: no overlap and transfer already low before reset rises
   a_r5_no_overlap : assert property (@(posedge clk) disable iff (!sp_n)
      !(xfer && pix_rst));
   a_r5_xfer_first : assert property (@(posedge clk) disable iff (!sp_n)
      $rose(pix_rst) |-> !$past(xfer));
   // R6: readout starts as transfer ends
   a_r6_scan_after_xfer : assert property (@(posedge clk) disable iff (!sp_n)
      $fell(xfer) |-> row_sel[0] && col_sel[0]);
endmodule

// File: tb/sim_snap_tgen.sv
module sim_snap_tgen;
   localparam int L = 2500, XW = 2, GW = 1, RW = 2, NR = 4, NC = 4;

   logic          clk = 1'b0;
   logic          sp_n = 1'b0;
   logic          frame_start, xfer, pix_rst;
   logic [NR-1:0] row_sel;
   logic [NC-1:0] col_sel;
   int            errors = 0, checks = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   snap_tgen #(.FRAME_LEN(L), .XFER_W(XW), .GAP_W(GW), .RST_W(RW),
               .ROWS(NR), .COLS(NC)) u0 (
      .clk(clk), .sp_n(sp_n), .frame_start(frame_start), .xfer(xfer),
      .pix_rst(pix_rst), .row_sel(row_sel), .col_sel(col_sel));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // expected outputs at frame position c (c < 0: idle)
   task automatic chk_pos(input string tag, input int c);
      int efs = 0, exf = 0, ers = 0, erow = 0, ecol = 0;
      if (c >= 0) begin
         efs = (c == 0);
         exf = (c < XW);
         ers = (c >= XW + GW) && (c < XW + GW + RW);
         if (c >= XW && c < XW + NR * NC) begin
            erow = 1 << ((c - XW) / NC);
            ecol = 1 << ((c - XW) % NC);
         end
      end
      chk({tag, " R2 frame_start"}, int'(frame_start), efs);
      chk({tag, " R3 xfer"},        int'(xfer), exf);
      chk({tag, " R4 pix_rst"},     int'(pix_rst), ers);
      chk({tag, " R6 row_sel"},     int'(row_sel), erow);
      chk({tag, " R7 col_sel"},     int'(col_sel), ecol);
   endtask

   // release the start line at a falling edge and follow n edges
   task automatic run_from_release(input string tag, input int n);
      sp_n = 1'b1;
      for (int e = 1; e <= n; e++) begin
         @(posedge clk); @(negedge clk);
         chk_pos(tag, (e >= 2) ? (e - 2) % L : -1);
      end
   endtask

   task automatic abort_now(input string tag);
      sp_n = 1'b0;
      @(posedge clk); @(negedge clk);
      chk_pos({tag, " R8 R1 abort"}, -1);
      repeat (3) begin
         @(posedge clk); @(negedge clk);
         chk_pos({tag, " R1 held"}, -1);
      end
   endtask

   task automatic t_reset_state();
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk_pos("reset R1", -1);
   endtask

   task automatic t_full_frames();
      run_from_release("frames", 2 * L + 30);
   endtask

   task automatic t_abort_readout();
      abort_now("mid-read");
      run_from_release("mid-read restart", 14);
      abort_now("mid-read2");
      run_from_release("R8 after read abort", 40);
   endtask

   task automatic t_abort_xfer();
      abort_now("xfer");
      run_from_release("xfer run", 3);
      abort_now("in-xfer");
      run_from_release("R8 after xfer abort", 40);
   endtask

   initial begin
      t_reset_state();
      @(negedge clk);
      t_full_frames();
      t_abort_readout();
      t_abort_xfer();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule